// File: doc/BRIEF.md
# Oversampling Serial Receiver with Idle-Line Wakeup

This block receives characters from an asynchronous NRZ serial line. The line must already be synchronized to the clock. A one-cycle sample enable, pulsing at sixteen times the bit rate, drives all of its timing. A character is a low start bit, then 8 or 9 data bits sent least-significant bit first, then a high stop bit. Each bit is decided by a three-sample majority vote taken around the middle of the bit. The bit timing realigns on every falling edge that appears inside a frame, so a sender whose rate differs from the local rate is still received correctly.

A finished character moves from the shift register into a holding register and raises a full flag. It stays there until the host pulses a read strobe, while the next character is shifted in. If a new character completes while the holding register is still full, the overrun flag is set and the older character is kept. Noise and framing-error flags travel with the character in the holding register.

A standby request puts the receiver into standby. In standby, completed characters are thrown away and the full flag stays low. The receiver leaves standby by itself when the line has stayed high for one whole character time, so the first character of the next message is captured.

Top module: `uart_wake_rx`

## Requirements
- R1: In 8-bit mode (`nine_bit`=0) a frame has a low start bit, 8 data bits sent LSB first, and a high stop bit. The data bits appear on `rx_data` with `rx_full`=1 and `rx_bit8`=0.
- R2: In 9-bit mode (`nine_bit`=1) the ninth data bit, which is sent last, appears on `rx_bit8`, and the first eight bits appear on `rx_data`.
- R3: A bit's value is the majority of the line samples at enable ticks 8, 9 and 10 of its 16. If one sample disagrees with the others, the character is still correct and `noise_err`=1 is reported with it. A clean character reports `noise_err`=0.
- R4: A low pulse that is gone before tick 8 of the start bit is rejected. No character is reported, and the receiver goes back to hunting for a start edge.
- R5: Each falling edge inside a frame realigns the bit timing. A 0x55 character sent at 18 ticks per bit, or at 14 ticks per bit, is received correctly.
- R6: If the stop bit votes low, `frame_err`=1 is reported with the character.
- R7: A character in the holding register stays unchanged while the next one is shifted in. If the host reads during that time, the next character is delivered without overrun.
- R8: If a character completes while `rx_full`=1, `overrun` is set and `rx_data` keeps the older character.
- R9: A one-cycle `rd_strobe` clears `rx_full` and `overrun`.
- R10: While `standby`=1, completed characters do not change `rx_full`.
- R11: In standby, the block clears `standby` after 10 bit times (8-bit mode) or 11 bit times (9-bit mode) of continuous high line, counted in enable ticks. The next character is then received.
- R12: `standby_req` sets `standby` on the next cycle and restarts the idle count.
- R13: After reset, `rx_full`, `overrun`, `noise_err`, `frame_err`, `standby` and `rx_data` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rxd | input | 1 | Synchronized serial line, idle high |
| tick16 | input | 1 | Sample enable at 16x the bit rate |
| nine_bit | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| standby_req | input | 1 | One-cycle request to enter standby |
| rd_strobe | input | 1 | One-cycle read of the holding register |
| rx_data | output | DATA_W | Held character, low data bits |
| rx_bit8 | output | 1 | Ninth data bit of the held character |
| rx_full | output | 1 | Holding register contains an unread character |
| overrun | output | 1 | A character was lost because the holding register was full |
| noise_err | output | 1 | Disagreeing samples in the held character |
| frame_err | output | 1 | Low stop bit in the held character |
| standby | output | 1 | Receiver is in wakeup standby |

## Verification
Characters are sent at exactly 16 ticks per bit in both frame lengths. This shows that the bit order and the position of the ninth bit are right. One sample inside a single bit is then flipped, which separates a correct majority vote from a single-sample decision and also exercises the noise flag. The same 0x55 pattern is sent at 18 and at 14 ticks per bit. With timing that only aligns to the start edge, these drift out of the sampling window; with per-edge realignment they land inside it. Back-to-back characters with and without a read in between, a short false start, a low stop bit, and idle runs just below and just above one character time show apart the overrun, hunting, framing and wakeup thresholds.

// File: rtl/uwr_pkg.sv
package uwr_pkg;
  typedef enum logic [1:0] {ST_HUNT, ST_START, ST_DATA, ST_STOP} uwr_state_e;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction
endpackage

// File: rtl/uwr_vote.sv
// Captures the first two mid-bit samples; the third is the live line.
module uwr_vote #(
  parameter int OVS = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   tick,
  input  logic                   rxd,
  input  logic [$clog2(OVS)-1:0] pos,
  output logic                   vote,
  output logic                   split
);
  localparam int PW = $clog2(OVS);
  localparam logic [PW-1:0] P_A = PW'(OVS/2 - 1);
  localparam logic [PW-1:0] P_B = PW'(OVS/2);

  logic s_a, s_b;

  always_ff @(posedge clk) begin
    if (rst) begin
      s_a <= 1'b1;
      s_b <= 1'b1;
    end else if (tick) begin
      if (pos == P_A) s_a <= rxd;
      if (pos == P_B) s_b <= rxd;
    end
  end

  assign vote  = uwr_pkg::maj3(s_a, s_b, rxd);
  assign split = !((s_a == s_b) && (s_b == rxd));
endmodule

// File: rtl/uwr_frame.sv
// Frame sequencer: start hunt, per-bit timing with edge realignment, shifting.
module uwr_frame import uwr_pkg::*; #(
  parameter int OVS    = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              rxd,
  input  logic              nine_bit,
  output logic              done,
  output logic [DATA_W-1:0] c_data,
  output logic              c_bit8,
  output logic              c_noise,
  output logic              c_ferr
);
  localparam int PW = $clog2(OVS);
  localparam int BW = $clog2(DATA_W + 1);
  localparam logic [PW-1:0] P_A    = PW'(OVS/2 - 1);
  localparam logic [PW-1:0] P_C    = PW'(OVS/2 + 1);
  localparam logic [PW-1:0] P_LAST = PW'(OVS - 1);
  localparam logic [PW-1:0] P_ONE  = PW'(1);

  uwr_state_e      state;
  logic [PW-1:0]   pos;
  logic [BW-1:0]   bitn;
  logic [DATA_W:0] sh;
  logic            prev, nacc;
  logic            vote, split, fall, adv;
  logic [BW-1:0]   last_bit;

  uwr_vote #(.OVS(OVS)) vote_i (
    .clk(clk), .rst(rst), .tick(tick), .rxd(rxd), .pos(pos),
    .vote(vote), .split(split)
  );

  assign fall     = tick && prev && !rxd;
  // a bit ends at its last tick, or early when the next bit's edge arrives after voting
  assign adv      = tick && ((pos == P_LAST) || (fall && (pos > P_C)));
  assign last_bit = nine_bit ? BW'(DATA_W) : BW'(DATA_W - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_HUNT;
      pos     <= '0;
      bitn    <= '0;
      sh      <= '0;
      prev    <= 1'b1;
      nacc    <= 1'b0;
      done    <= 1'b0;
      c_data  <= '0;
      c_bit8  <= 1'b0;
      c_noise <= 1'b0;
      c_ferr  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (tick) begin
        prev <= rxd;
        pos  <= (pos == P_LAST) ? '0 : pos + 1'b1;
        if (state == ST_HUNT) begin
          if (fall) begin
            state <= ST_START;
            pos   <= P_ONE;
            nacc  <= 1'b0;
          end
        end else begin
          if (fall && (pos < P_A)) pos <= P_ONE;
          if (pos == P_C) begin
            nacc <= nacc | split;
            case (state)
              ST_START: if (vote) state <= ST_HUNT;
              ST_DATA:  sh <= {vote, sh[DATA_W:1]};
              ST_STOP: begin
                done    <= 1'b1;
                c_data  <= nine_bit ? sh[DATA_W-1:0] : sh[DATA_W:1];
                c_bit8  <= nine_bit & sh[DATA_W];
                c_noise <= nacc | split;
                c_ferr  <= !vote;
                state   <= ST_HUNT;
              end
              default: ;
            endcase
          end
          if (adv) begin
            if (fall) pos <= P_ONE;
            case (state)
              ST_START: begin
                state <= ST_DATA;
                bitn  <= '0;
              end
              ST_DATA: begin
                if (bitn == last_bit) state <= ST_STOP;
                else bitn <= bitn + 1'b1;
              end
              default: ;
            endcase
          end
        end
      end
    end
  end
endmodule

// File: rtl/uwr_hold.sv
// Holding register with full, overrun and per-character error flags.
module uwr_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              done,
  input  logic [DATA_W-1:0] c_data,
  input  logic              c_bit8,
  input  logic              c_noise,
  input  logic              c_ferr,
  input  logic              standby,
  input  logic              rd,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_bit8,
  output logic              rx_full,
  output logic              overrun,
  output logic              noise_err,
  output logic              frame_err
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rx_data   <= '0;
      rx_bit8   <= 1'b0;
      rx_full   <= 1'b0;
      overrun   <= 1'b0;
      noise_err <= 1'b0;
      frame_err <= 1'b0;
    end else begin
      if (rd) begin
        rx_full <= 1'b0;
        overrun <= 1'b0;
      end
      if (done && !standby) begin
        if (rx_full && !rd) begin
          overrun <= 1'b1;
        end else begin
          rx_data   <= c_data;
          rx_bit8   <= c_bit8;
          noise_err <= c_noise;
          frame_err <= c_ferr;
          rx_full   <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/uwr_idle.sv
// Standby state and idle-line detector that ends it.
module uwr_idle #(
  parameter int OVS    = 16,
  parameter int DATA_W = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic rxd,
  input  logic nine_bit,
  input  logic standby_req,
  output logic standby
);
  localparam int LIM8 = OVS * (DATA_W + 2);
  localparam int LIM9 = OVS * (DATA_W + 3);
  localparam int CW   = $clog2(LIM9 + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] limit;

  assign limit = nine_bit ? CW'(LIM9 - 1) : CW'(LIM8 - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      standby <= 1'b0;
      cnt     <= '0;
    end else if (standby_req) begin
      standby <= 1'b1;
      cnt     <= '0;
    end else if (!standby) begin
      cnt <= '0;
    end else if (tick) begin
      if (!rxd) begin
        cnt <= '0;
      end else if (cnt >= limit) begin
        standby <= 1'b0;
        cnt     <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/uart_wake_rx.sv
module uart_wake_rx #(
  parameter int OVS    = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rxd,
  input  logic              tick16,
  input  logic              nine_bit,
  input  logic              standby_req,
  input  logic              rd_strobe,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_bit8,
  output logic              rx_full,
  output logic              overrun,
  output logic              noise_err,
  output logic              frame_err,
  output logic              standby
);
  logic              frame_done;
  logic [DATA_W-1:0] c_data;
  logic              c_bit8, c_noise, c_ferr;

  uwr_frame #(.OVS(OVS), .DATA_W(DATA_W)) frame_i (
    .clk(clk), .rst(rst), .tick(tick16), .rxd(rxd), .nine_bit(nine_bit),
    .done(frame_done), .c_data(c_data), .c_bit8(c_bit8),
    .c_noise(c_noise), .c_ferr(c_ferr)
  );

  uwr_idle #(.OVS(OVS), .DATA_W(DATA_W)) idle_i (
    .clk(clk), .rst(rst), .tick(tick16), .rxd(rxd), .nine_bit(nine_bit),
    .standby_req(standby_req), .standby(standby)
  );

  uwr_hold #(.DATA_W(DATA_W)) hold_i (
    .clk(clk), .rst(rst), .done(frame_done), .c_data(c_data), .c_bit8(c_bit8),
    .c_noise(c_noise), .c_ferr(c_ferr), .standby(standby), .rd(rd_strobe),
    .rx_data(rx_data), .rx_bit8(rx_bit8), .rx_full(rx_full), .overrun(overrun),
    .noise_err(noise_err), .frame_err(frame_err)
  );
endmodule

// File: rtl/uwr_chk.sv
module uwr_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              rd_strobe,
  input logic              standby_req,
  input logic              standby,
  input logic              rx_full,
  input logic              overrun,
  input logic              frame_done,
  input logic [DATA_W-1:0] rx_data
);
  // R8
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_full && !rd_strobe) |=> $stable(rx_data));

  // R8
  overrun_full_chk: assert property (@(posedge clk) disable iff (rst)
    overrun |-> rx_full);

  // R9
  read_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_strobe && !frame_done) |=> !rx_full);

  // R10
  standby_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (standby && !rx_full) |=> !rx_full);

  // R12
  standby_enter_chk: assert property (@(posedge clk) disable iff (rst)
    standby_req |=> standby);
endmodule

bind uart_wake_rx uwr_chk #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst(rst), .rd_strobe(rd_strobe), .standby_req(standby_req),
  .standby(standby), .rx_full(rx_full), .overrun(overrun),
  .frame_done(frame_done), .rx_data(rx_data)
);

// File: tb/uart_wake_rx_tb.sv
module uart_wake_rx_tb_top;
  localparam int PER = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rxd = 1'b1;
  logic       tick16 = 1'b0;
  logic       nine_bit = 1'b0;
  logic       standby_req = 1'b0;
  logic       rd_strobe = 1'b0;
  logic [7:0] rx_data;
  logic       rx_bit8, rx_full, overrun, noise_err, frame_err, standby;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  uart_wake_rx dut_i (
    .clk(clk), .rst(rst), .rxd(rxd), .tick16(tick16), .nine_bit(nine_bit),
    .standby_req(standby_req), .rd_strobe(rd_strobe), .rx_data(rx_data),
    .rx_bit8(rx_bit8), .rx_full(rx_full), .overrun(overrun),
    .noise_err(noise_err), .frame_err(frame_err), .standby(standby)
  );

  always #5 clk = ~clk;

  // sample enable on every other clock
  initial begin
    forever begin
      @(negedge clk);
      tick16 = rst ? 1'b0 : ~tick16;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic line(input logic v, input int nt);
    rxd = v;
    for (int k = 0; k < nt; ) begin
      @(posedge clk);
      if (tick16) k++;
    end
    #1;
  endtask

  task automatic send_char(input logic [8:0] d, input logic nine, input int per,
                           input int flip_bit, input logic stop_v);
    line(1'b0, per);
    for (int i = 0; i < (nine ? 9 : 8); i++) begin
      if (i == flip_bit) begin
        line(d[i], 8);
        line(~d[i], 1);
        line(d[i], per - 9);
      end else begin
        line(d[i], per);
      end
    end
    line(stop_v, per);
    rxd = 1'b1;
    @(negedge clk);
  endtask

  task automatic do_read();
    @(negedge clk) rd_strobe = 1'b1;
    @(negedge clk) rd_strobe = 1'b0;
  endtask

  task automatic do_standby();
    @(negedge clk) standby_req = 1'b1;
    @(negedge clk) standby_req = 1'b0;
  endtask

  task automatic t_reset();
    chk("R13 full", 32'(rx_full), 0);
    chk("R13 overrun", 32'(overrun), 0);
    chk("R13 noise", 32'(noise_err), 0);
    chk("R13 ferr", 32'(frame_err), 0);
    chk("R13 standby", 32'(standby), 0);
    chk("R13 data", 32'(rx_data), 0);
  endtask

  task automatic t_basic8();
    send_char(9'h0A5, 1'b0, PER, -1, 1'b1);
    chk("R1 data", 32'(rx_data), 32'hA5);
    chk("R1 bit8", 32'(rx_bit8), 0);
    chk("R1 full", 32'(rx_full), 1);
    chk("R3 clean noise", 32'(noise_err), 0);
    chk("R6 clean ferr", 32'(frame_err), 0);
    do_read();
    @(negedge clk);
    chk("R9 read clears full", 32'(rx_full), 0);
    send_char(9'h03C, 1'b0, PER, -1, 1'b1);
    chk("R1 data second", 32'(rx_data), 32'h3C);
    do_read();
  endtask

  task automatic t_nine();
    nine_bit = 1'b1;
    send_char(9'h1A5, 1'b1, PER, -1, 1'b1);
    chk("R2 data", 32'(rx_data), 32'hA5);
    chk("R2 bit8", 32'(rx_bit8), 1);
    do_read();
    nine_bit = 1'b0;
  endtask

  task automatic t_noise();
    send_char(9'h05A, 1'b0, PER, 3, 1'b1);
    chk("R3 data", 32'(rx_data), 32'h5A);
    chk("R3 noise", 32'(noise_err), 1);
    do_read();
    send_char(9'h05A, 1'b0, PER, 2, 1'b1);
    chk("R3 data low bit", 32'(rx_data), 32'h5A);
    chk("R3 noise low bit", 32'(noise_err), 1);
    do_read();
  endtask

  task automatic t_false_start();
    line(1'b0, 3);
    line(1'b1, 3 * PER);
    chk("R4 no char", 32'(rx_full), 0);
    send_char(9'h081, 1'b0, PER, -1, 1'b1);
    chk("R4 hunt resumes", 32'(rx_data), 32'h81);
    do_read();
  endtask

  task automatic t_resync();
    send_char(9'h055, 1'b0, 18, -1, 1'b1);
    chk("R5 slow sender", 32'(rx_data), 32'h55);
    chk("R5 slow full", 32'(rx_full), 1);
    do_read();
    line(1'b1, PER);
    send_char(9'h055, 1'b0, 14, -1, 1'b1);
    chk("R5 fast sender", 32'(rx_data), 32'h55);
    do_read();
    line(1'b1, PER);
  endtask

  task automatic t_ferr();
    send_char(9'h033, 1'b0, PER, -1, 1'b0);
    line(1'b1, 2 * PER);
    chk("R6 ferr", 32'(frame_err), 1);
    chk("R6 data", 32'(rx_data), 32'h33);
    do_read();
  endtask

  task automatic t_double();
    send_char(9'h011, 1'b0, PER, -1, 1'b1);
    fork
      send_char(9'h022, 1'b0, PER, -1, 1'b1);
      begin
        repeat (5 * PER * 2) @(negedge clk);
        chk("R7 first held", 32'(rx_data), 32'h11);
        do_read();
      end
    join
    chk("R7 second data", 32'(rx_data), 32'h22);
    chk("R7 second full", 32'(rx_full), 1);
    chk("R7 no overrun", 32'(overrun), 0);
    do_read();
  endtask

  task automatic t_overrun();
    send_char(9'h044, 1'b0, PER, -1, 1'b1);
    send_char(9'h077, 1'b0, PER, -1, 1'b1);
    chk("R8 overrun", 32'(overrun), 1);
    chk("R8 old kept", 32'(rx_data), 32'h44);
    do_read();
    @(negedge clk);
    chk("R9 overrun cleared", 32'(overrun), 0);
    chk("R9 full cleared", 32'(rx_full), 0);
  endtask

  task automatic t_standby8();
    line(1'b1, 12 * PER);
    do_standby();
    chk("R12 enter", 32'(standby), 1);
    line(1'b1, 5 * PER);
    chk("R12 count restarted", 32'(standby), 1);
    send_char(9'h03C, 1'b0, PER, -1, 1'b1);
    chk("R10 no full", 32'(rx_full), 0);
    line(1'b1, 8 * PER);
    chk("R11 below idle time", 32'(standby), 1);
    line(1'b1, 2 * PER);
    chk("R11 woke 8-bit", 32'(standby), 0);
    send_char(9'h05A, 1'b0, PER, -1, 1'b1);
    chk("R11 next char", 32'(rx_data), 32'h5A);
    chk("R11 next full", 32'(rx_full), 1);
    do_read();
  endtask

  task automatic t_standby9();
    nine_bit = 1'b1;
    do_standby();
    send_char(9'h0A5, 1'b1, PER, -1, 1'b1);
    chk("R10 no full 9-bit", 32'(rx_full), 0);
    line(1'b1, 9 * PER);
    chk("R11 below idle 9-bit", 32'(standby), 1);
    line(1'b1, 2 * PER);
    chk("R11 woke 9-bit", 32'(standby), 0);
    nine_bit = 1'b0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog R0 actual=running expected=done");
    summary();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    t_reset();
    t_basic8();
    t_nine();
    t_noise();
    t_false_start();
    t_resync();
    t_ferr();
    t_double();
    t_overrun();
    t_standby8();
    t_standby9();
    repeat (10) @(negedge clk);
    summary();
  end
endmodule